// File: doc/BRIEF.md
# Free-Running Capture/Compare Timer

This block is a free-running up-counter with one input-capture channel and two output-compare channels. The counter advances by one on every clock. A selected edge on the capture input stores the counter value in a capture register. When the counter equals either compare register, that channel's output pin is driven to a programmed level. Four event flags record capture, compare A, compare B and counter wrap. Each flag, gated by its own enable bit, drives a level interrupt request.

A CPU reaches the registers through a simple bus. Reads are combinational and writes take effect at the clock edge. A flag is cleared in one of two ways. The first is a CPU read of the status register that sees the flag at 1, followed by a write of 0 to that bit. The second is a pulse on the acknowledge input that a transfer controller raises when it services the interrupt. The wrap flag has no acknowledge input.

Register map (addr): 0 counter (read/write), 1 capture (read only), 2 compare A, 3 compare B, 4 control, 5 status. Other addresses read 0.

Top module: `ftimer_cc`

## Requirements
- R1: The counter adds one on every clock edge. A write to addr 0 loads the written value in place of that edge's increment.
- R2: When the counter advances from 0xFFFF to 0x0000, status bit 3 (wrap flag) is set at that same edge.
- R3: Control bit 4 selects the capture edge: 1 for rising, 0 for falling. The capture input passes through two synchronizing flops. On the selected edge, the capture register receives the counter value two cycles after the input changed, and status bit 0 is set.
- R4: While the counter equals compare A (or compare B), status bit 1 (or bit 2) is set at the next clock edge.
- R5: At a compare match, output pin A (or B) takes the value of control bit 5 (or bit 6). The pin holds that level between matches and is 0 after reset.
- R6: A read of addr 5 arms every flag that reads as 1. A later write to addr 5 clears each armed flag whose written bit is 0. Every write to addr 5 disarms all flags.
- R7: A write of 0 to a flag that has not been armed has no effect. Writing 1 to a flag bit never changes it.
- R8: A pulse on the capture, compare A or compare B acknowledge input clears status bit 0, 1 or 2 respectively. No acknowledge clears the wrap flag.
- R9: When a flag's set event and a clearing write or acknowledge happen on the same edge, the flag ends up set.
- R10: Each interrupt output equals its flag ANDed with its control enable bit: bit 0 capture, bit 1 compare A, bit 2 compare B, bit 3 wrap.
- R11: After reset, the status and control registers read 0, the compare registers read 0xFFFF and all pins and interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms flags on status reads) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| cap_in | input | 1 | Asynchronous capture input |
| ack_cap | input | 1 | Transfer-controller service of capture interrupt |
| ack_cmpa | input | 1 | Transfer-controller service of compare A interrupt |
| ack_cmpb | input | 1 | Transfer-controller service of compare B interrupt |
| cmp_out_a | output | 1 | Compare A output pin |
| cmp_out_b | output | 1 | Compare B output pin |
| irq_cap | output | 1 | Capture interrupt request |
| irq_cmpa | output | 1 | Compare A interrupt request |
| irq_cmpb | output | 1 | Compare B interrupt request |
| irq_ovf | output | 1 | Wrap interrupt request |

## Verification
A stale or missing arm bit shows up at the ports as a wrong result on the next status write. Either a flag clears without the read step, or a flag survives a proper read-then-write; both are visible on the interrupt outputs one cycle after that write. A counter that is off by one moves the capture value and the compare match cycle by one, so the bench checks the capture register and the flag edges at exact cycles. A wrong synchronizer depth shifts the capture flag by one clock.

// File: rtl/ftimer_cc.sv
module ftimer_cc #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   bus_addr,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic         cap_in,
  input  logic         ack_cap,
  input  logic         ack_cmpa,
  input  logic         ack_cmpb,
  output logic         cmp_out_a,
  output logic         cmp_out_b,
  output logic         irq_cap,
  output logic         irq_cmpa,
  output logic         irq_cmpb,
  output logic         irq_ovf
);
  localparam logic [2:0] A_CNT = 3'd0, A_ICR = 3'd1, A_OCA = 3'd2,
                         A_OCB = 3'd3, A_CTL = 3'd4, A_STS = 3'd5;

  logic [W-1:0] cnt, icr, oca, ocb;
  logic [6:0]   ctl;
  logic [3:0]   flags, armed, set_ev, clr_ev, flags_n;
  logic [2:0]   sync;

  wire cnt_wr  = bus_wr && bus_addr == A_CNT;
  wire sts_wr  = bus_wr && bus_addr == A_STS;
  wire sts_rd  = bus_rd && bus_addr == A_STS;
  wire match_a = cnt == oca;
  wire match_b = cnt == ocb;
  wire ovf_set = !cnt_wr && (cnt == {W{1'b1}});
  wire cap_evt = ctl[4] ? (sync[1] & ~sync[2]) : (~sync[1] & sync[2]);

  // counter and registers
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0;
      icr <= '0;
      oca <= '1;
      ocb <= '1;
      ctl <= '0;
    end else begin
      cnt <= cnt_wr ? bus_wdata : cnt + 1'b1;
      if (cap_evt) icr <= cnt;
      if (bus_wr && bus_addr == A_OCA) oca <= bus_wdata;
      if (bus_wr && bus_addr == A_OCB) ocb <= bus_wdata;
      if (bus_wr && bus_addr == A_CTL) ctl <= bus_wdata[6:0];
    end

  // capture synchronizer and edge history
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= '0;
    else        sync <= {sync[1:0], cap_in};

  // flag logic: set beats clear
  assign set_ev  = {ovf_set, match_b, match_a, cap_evt};
  assign clr_ev  = ({4{sts_wr}} & ~bus_wdata[3:0] & armed)
                 | {1'b0, ack_cmpb, ack_cmpa, ack_cap};
  assign flags_n = set_ev | (flags & ~clr_ev);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flags <= '0;
      armed <= '0;
    end else begin
      flags <= flags_n;
      if (sts_wr) armed <= '0;
      else        armed <= (armed | (sts_rd ? flags : 4'b0)) & flags_n;
    end

  // compare pins
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmp_out_a <= 1'b0;
      cmp_out_b <= 1'b0;
    end else begin
      if (match_a) cmp_out_a <= ctl[5];
      if (match_b) cmp_out_b <= ctl[6];
    end

  assign {irq_ovf, irq_cmpb, irq_cmpa, irq_cap} = flags & ctl[3:0];

  always_comb
    case (bus_addr)
      A_CNT:   bus_rdata = cnt;
      A_ICR:   bus_rdata = icr;
      A_OCA:   bus_rdata = oca;
      A_OCB:   bus_rdata = ocb;
      A_CTL:   bus_rdata = {{(W-7){1'b0}}, ctl};
      A_STS:   bus_rdata = {{(W-4){1'b0}}, flags};
      default: bus_rdata = '0;
    endcase

  assert_ovf_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == {W{1'b1}} && !cnt_wr) |=> (flags[3] && cnt == '0));
  assert_capture_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (icr == $past(cnt) && flags[0]));
  assert_pin_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match_a |=> cmp_out_a == $past(ctl[5]));
  assert_write_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && bus_wdata[3] && !flags[3] && !ovf_set) |=> !flags[3]);
  assert_ack_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_cmpa && !match_a) |=> !flags[1]);
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (match_b && (ack_cmpb || sts_wr)) |=> flags[2]);
endmodule

// File: tb/ftimer_cc_tb.sv
module ftimer_cc_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic cap_in = 1'b0, ack_cap = 1'b0, ack_cmpa = 1'b0, ack_cmpb = 1'b0;
  logic cmp_out_a, cmp_out_b, irq_cap, irq_cmpa, irq_cmpb, irq_ovf;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ftimer_cc #(.W(16)) dut_i (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(5, v); chk("R11 status", v, 16'h0);
    rd(4, v); chk("R11 control", v, 16'h0);
    rd(2, v); chk("R11 compare A", v, 16'hFFFF);
    chk("R11 pins/irqs", {cmp_out_a, cmp_out_b, irq_cap, irq_cmpa, irq_cmpb, irq_ovf}, 16'h0);
  endtask

  task automatic t_count;
    logic [15:0] v;
    wr(0, 16'h1234);
    rd(0, v); chk("R1 load", v, 16'h1234);
    rd(0, v); chk("R1 increment", v, 16'h1235);
  endtask

  task automatic t_wrap_and_clear;
    logic [15:0] v;
    wr(2, 16'h4000); wr(3, 16'h4000); wr(4, 16'h0008);
    wr(0, 16'hFFFD);
    rd(5, v); chk("R2 before wrap", v & 16'h8, 16'h0);
    rd(5, v); chk("R2 at FFFE", v & 16'h8, 16'h0);
    rd(5, v); chk("R2 at FFFF", v & 16'h8, 16'h0);
    rd(5, v); chk("R2 wrap sets flag", v & 16'h8, 16'h8);
    chk("R10 irq_ovf follows flag", irq_ovf, 1'b1);
    wr(5, 16'h0);
    chk("R6 read-then-write clears", irq_ovf, 1'b0);
    wr(0, 16'hFFFF);
    @(negedge clk);
    chk("R2 wrap after load", irq_ovf, 1'b1);
    wr(5, 16'h0);
    chk("R7 write without read ignored", irq_ovf, 1'b1);
    ack_cap = 1'b1; ack_cmpa = 1'b1; ack_cmpb = 1'b1;
    @(negedge clk);
    ack_cap = 1'b0; ack_cmpa = 1'b0; ack_cmpb = 1'b0;
    chk("R8 no ack path for wrap", irq_ovf, 1'b1);
    rd(5, v);
    wr(5, 16'h000F);
    chk("R7 write of one ignored", irq_ovf, 1'b1);
    wr(5, 16'h0);
    chk("R6 write disarms", irq_ovf, 1'b1);
    rd(5, v);
    wr(5, 16'h0);
    chk("R6 second sequence clears", irq_ovf, 1'b0);
  endtask

  task automatic t_capture;
    logic [15:0] v;
    wr(4, 16'h0011);
    wr(0, 16'h0100);
    cap_in = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3 sync delay", irq_cap, 1'b0);
    @(negedge clk);
    chk("R3 rising capture flag", irq_cap, 1'b1);
    rd(1, v); chk("R3 rising capture value", v, 16'h0102);
    ack_cap = 1'b1; @(negedge clk); ack_cap = 1'b0;
    chk("R8 capture ack clears", irq_cap, 1'b0);
    wr(4, 16'h0001);
    wr(0, 16'h0200);
    cap_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 falling capture flag", irq_cap, 1'b1);
    rd(1, v); chk("R3 falling capture value", v, 16'h0202);
    ack_cap = 1'b1; @(negedge clk); ack_cap = 1'b0;
  endtask

  task automatic t_compare;
    wr(4, 16'h0026);
    wr(2, 16'h0305); wr(3, 16'h0307);
    wr(0, 16'h0300);
    repeat (5) @(negedge clk);
    chk("R4 compare A not yet", {irq_cmpa, cmp_out_a}, 16'h0);
    @(negedge clk);
    chk("R4 compare A flag", irq_cmpa, 1'b1);
    chk("R5 pin A level", cmp_out_a, 1'b1);
    @(negedge clk);
    chk("R4 compare B not yet", irq_cmpb, 1'b0);
    @(negedge clk);
    chk("R4 compare B flag", irq_cmpb, 1'b1);
    chk("R5 pin B level", cmp_out_b, 1'b0);
    ack_cmpa = 1'b1; ack_cmpb = 1'b1; @(negedge clk);
    ack_cmpa = 1'b0; ack_cmpb = 1'b0;
    chk("R8 compare acks clear", {irq_cmpa, irq_cmpb}, 16'h0);
    repeat (4) @(negedge clk);
    chk("R5 pin A holds", cmp_out_a, 1'b1);
    wr(4, 16'h0006);
    wr(0, 16'h0300);
    repeat (6) @(negedge clk);
    chk("R5 pin A drives new level", cmp_out_a, 1'b0);
  endtask

  task automatic t_set_wins;
    logic [15:0] v;
    rd(5, v); chk("R9 flag A set before", v & 16'h2, 16'h2);
    wr(0, 16'h0300);
    repeat (5) @(negedge clk);
    wr(5, 16'h0);
    chk("R9 set beats clearing write", irq_cmpa, 1'b1);
    wr(0, 16'h0300);
    repeat (7) @(negedge clk);
    ack_cmpb = 1'b1; @(negedge clk); ack_cmpb = 1'b0;
    chk("R9 set beats ack", irq_cmpb, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_wrap_and_clear();
    t_capture();
    t_compare();
    t_set_wins();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule